// File: doc/BRIEF.md
# Global 64-bit Timer with Compare Channel

This block keeps a 64-bit free-running up-counter and one 64-bit compare channel behind a small 32-bit register bus, and drives a level interrupt. Software reads or loads the counter as two 32-bit halves, programs a compare value in halves, and may set a 32-bit increment. When the counter equals the compare value while the comparator is enabled, a sticky interrupt status bit sets. With auto-increment on, each match also adds the increment to the compare value, so the interrupt repeats with a fixed period.

Writes to the six tracked registers (both counter halves, both compare halves, the increment and the control register) do not land at once. They move through a delay line of `WR_DELAY` cycles. Each tracked register has a sticky completion flag that sets in the cycle its value lands. Software polls the flag and clears it by writing a one to its bit. Reads are combinational from the addressed register.

Top module: `gtimer_cmp`

## Requirements
- R1: After reset every readable register at offsets 0x100, 0x104, 0x110, 0x200, 0x204, 0x208, 0x240, 0x244, 0x248 and 0x24C reads zero, and `irq` is low.
- R2: A write to a tracked register (counter low 0x100, counter high 0x104, compare low 0x200, compare high 0x204, increment 0x208, control 0x240) changes neither that register nor its flag for WR_DELAY cycles. The new value and the flag appear together after exactly WR_DELAY clock edges. The flags are: 0x110 bit 0 (counter low) and bit 1 (counter high); 0x24C bit 0 (compare low), bit 1 (compare high), bit 2 (increment) and bit 16 (control).
- R3: Writing to 0x110 or 0x24C clears, at the bus write's own clock edge, exactly the flag bits written as one. All other flags are kept. A flag that is being set in the same cycle stays set.
- R4: While control bit 8 is set, the counter advances by one on every clock edge. While it is clear, the counter holds.
- R5: A landed write to a counter half loads that half only while the counter is stopped. While the counter runs, the write is dropped, but its flag still sets.
- R6: The counter counts across all 64 bits. The carry from the low half into the high half appears on the same edge.
- R7: When control bit 0 is set and the counter equals the compare value, interrupt status bit 0 (0x244) sets on the next edge. `irq` is the status bit gated by enable bit 0 (0x248).
- R8: With control bits 0 and 1 both set, each match adds the increment register to the compare value on the same edge. This gives an interrupt period equal to the increment.
- R9: With control bit 1 clear, a match leaves the compare value unchanged.
- R10: Writing one to bit 0 of 0x244 clears the interrupt status at that edge. A match in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| irq | output | 1 | Level interrupt |

## Verification
The W1C clears of the flag registers, the interrupt enable and the interrupt status act at the bus write's own edge, so they are checked at the half-cycle right after that edge. A tracked write is sampled once per cycle for WR_DELAY cycles, where it must still show the old value and a clear flag. On the next sample it must show both the new value and the flag. Counter reads are tied to exact edge counts: a running-write retire is expected at the earlier sample plus 2 + WR_DELAY. Interrupt timing is measured with a bench cycle counter. The first status sighting must see the counter at compare+1, and successive periodic sightings must lie exactly one increment apart.

// File: rtl/gtimer_cmp.sv
`timescale 1ns/1ps
module gtimer_cmp #(
  parameter int ADDR_W   = 12,
  parameter int WR_DELAY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(12'h100);
  localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(12'h104);
  localparam logic [ADDR_W-1:0] A_CNT_WS = ADDR_W'(12'h110);
  localparam logic [ADDR_W-1:0] A_CMP_LO = ADDR_W'(12'h200);
  localparam logic [ADDR_W-1:0] A_CMP_HI = ADDR_W'(12'h204);
  localparam logic [ADDR_W-1:0] A_INC    = ADDR_W'(12'h208);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(12'h240);
  localparam logic [ADDR_W-1:0] A_ISTAT  = ADDR_W'(12'h244);
  localparam logic [ADDR_W-1:0] A_IEN    = ADDR_W'(12'h248);
  localparam logic [ADDR_W-1:0] A_GWS    = ADDR_W'(12'h24C);
  localparam int LAST = WR_DELAY - 1;

  localparam logic [2:0] T_CNTL = 3'd0, T_CNTH = 3'd1, T_CMPL = 3'd2,
                         T_CMPH = 3'd3, T_INC  = 3'd4, T_CTRL = 3'd5;

  logic [63:0] cnt, cmp;
  logic [31:0] incr;
  logic        run, cen, ainc, int_stat, int_en;
  logic [1:0]  cws;
  logic [3:0]  gws;

  logic        trk;
  logic [2:0]  tgt;
  always_comb begin
    trk = 1'b1;
    tgt = T_CNTL;
    case (addr)
      A_CNT_LO: tgt = T_CNTL;
      A_CNT_HI: tgt = T_CNTH;
      A_CMP_LO: tgt = T_CMPL;
      A_CMP_HI: tgt = T_CMPH;
      A_INC:    tgt = T_INC;
      A_CTRL:   tgt = T_CTRL;
      default:  trk = 1'b0;
    endcase
  end

  logic [WR_DELAY-1:0] pv;
  logic [2:0]          pt [WR_DELAY];
  logic [31:0]         pd [WR_DELAY];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv <= '0;
    else begin
      pv[0] <= wr_en && trk;
      for (int i = 1; i < WR_DELAY; i++) pv[i] <= pv[i-1];
    end
  end

  always_ff @(posedge clk) begin
    pt[0] <= tgt;
    pd[0] <= wdata;
    for (int i = 1; i < WR_DELAY; i++) begin
      pt[i] <= pt[i-1];
      pd[i] <= pd[i-1];
    end
  end

  logic        ap_v;
  logic [2:0]  ap_t;
  logic [31:0] ap_d;
  assign ap_v = pv[LAST];
  assign ap_t = pt[LAST];
  assign ap_d = pd[LAST];

  logic cnt_ld, cmp_ld, hit;
  assign cnt_ld = ap_v && !run && (ap_t == T_CNTL || ap_t == T_CNTH);
  assign cmp_ld = ap_v && (ap_t == T_CMPL || ap_t == T_CMPH);
  assign hit    = cen && (cnt == cmp);

  logic clr_istat, clr_cws, clr_gws, set_ien;
  assign clr_istat = wr_en && addr == A_ISTAT && wdata[0];
  assign clr_cws   = wr_en && addr == A_CNT_WS;
  assign clr_gws   = wr_en && addr == A_GWS;
  assign set_ien   = wr_en && addr == A_IEN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt_ld && ap_t == T_CNTL) cnt[31:0]  <= ap_d;
    else if (cnt_ld)                   cnt[63:32] <= ap_d;
    else if (run)                      cnt <= cnt + 64'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp <= '0;
    else if (ap_v && ap_t == T_CMPL) cmp[31:0]  <= ap_d;
    else if (ap_v && ap_t == T_CMPH) cmp[63:32] <= ap_d;
    else if (hit && ainc)            cmp <= cmp + {32'd0, incr};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      incr <= '0;
      {run, ainc, cen} <= '0;
    end else if (ap_v && ap_t == T_INC) incr <= ap_d;
    else if (ap_v && ap_t == T_CTRL) {run, ainc, cen} <= {ap_d[8], ap_d[1], ap_d[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_stat <= 1'b0;
      int_en   <= 1'b0;
    end else begin
      if (hit)            int_stat <= 1'b1;
      else if (clr_istat) int_stat <= 1'b0;
      if (set_ien)        int_en   <= wdata[0];
    end
  end

  logic [1:0] cws_set, cws_clr;
  logic [3:0] gws_set, gws_clr;
  assign cws_set = {ap_v && ap_t == T_CNTH, ap_v && ap_t == T_CNTL};
  assign gws_set = {ap_v && ap_t == T_CTRL, ap_v && ap_t == T_INC,
                    ap_v && ap_t == T_CMPH, ap_v && ap_t == T_CMPL};
  assign cws_clr = clr_cws ? wdata[1:0] : 2'b00;
  assign gws_clr = clr_gws ? {wdata[16], wdata[2:0]} : 4'b0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cws <= '0;
      gws <= '0;
    end else begin
      cws <= cws_set | (cws & ~cws_clr);
      gws <= gws_set | (gws & ~gws_clr);
    end
  end

  always_comb begin
    case (addr)
      A_CNT_LO: rdata = cnt[31:0];
      A_CNT_HI: rdata = cnt[63:32];
      A_CNT_WS: rdata = {30'd0, cws};
      A_CMP_LO: rdata = cmp[31:0];
      A_CMP_HI: rdata = cmp[63:32];
      A_INC:    rdata = incr;
      A_CTRL:   rdata = {23'd0, run, 6'd0, ainc, cen};
      A_ISTAT:  rdata = {31'd0, int_stat};
      A_IEN:    rdata = {31'd0, int_en};
      A_GWS:    rdata = {15'd0, gws[3], 13'd0, gws[2:0]};
      default:  rdata = 32'd0;
    endcase
  end

  assign irq = int_stat & int_en;

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> cnt == $past(cnt) + 64'd1);
  // R5
  cnt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_ld) |=> $stable(cnt));
  // R7
  match_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> int_stat);
  // R8
  ainc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ainc && !cmp_ld) |=> cmp == $past(cmp) + 64'($past(incr)));
  // R9
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(hit && ainc) && !cmp_ld) |=> $stable(cmp));
  // R2
  ctrl_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_v && ap_t == T_CTRL) |=> gws[3]);
  // R3
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gws[3]) |-> $past(ap_v && ap_t == T_CTRL));
endmodule

// File: tb/sim_gtimer_cmp.sv
`timescale 1ns/1ps
module sim_gtimer_cmp;
  localparam int D = 3;
  localparam logic [11:0] CNTL = 12'h100, CNTH = 12'h104, CWS = 12'h110,
                          CMPL = 12'h200, CMPH = 12'h204, INC = 12'h208,
                          CTRL = 12'h240, ISTAT = 12'h244, IEN = 12'h248,
                          GWS = 12'h24C;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;
  int checks = 0, errors = 0;
  longint cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  gtimer_cmp #(.ADDR_W(12), .WR_DELAY(D)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #0.1;
    d = rdata;
  endtask

  task automatic settle();
    repeat (D) @(negedge clk);
  endtask

  function automatic logic [11:0] reg_of(input int i);
    case (i)
      0: return CNTL; 1: return CNTH; 2: return CMPL;
      3: return CMPH; 4: return INC;  default: return CTRL;
    endcase
  endfunction

  function automatic logic [11:0] flag_reg(input int i);
    return (i < 2) ? CWS : GWS;
  endfunction

  function automatic logic [31:0] flag_mask(input int i);
    case (i)
      0: return 32'h1; 1: return 32'h2; 2: return 32'h1;
      3: return 32'h2; 4: return 32'h4; default: return 32'h10000;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r, a, b, c, hi, lo;
    logic [63:0] prev, cur;
    longint t0, t;
    int incs [4] = '{3, 4, 7, 16};
    logic [11:0] all_regs [10] = '{CNTL, CNTH, CWS, CMPL, CMPH, INC, CTRL, ISTAT, IEN, GWS};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    foreach (all_regs[k]) begin
      rd(all_regs[k], r);
      chk("R1 reset value", r, 0);
    end
    chk("R1 irq low", irq, 0);

    // R2 delay sweep over every tracked register
    for (int i = 0; i < 6; i++) begin
      logic [31:0] v;
      v = (i == 5) ? 32'h2 : (32'hA5C3_0000 | 32'(i * 7 + 1));
      wr(reg_of(i), v);
      for (int k = 0; k < D; k++) begin
        rd(reg_of(i), r);
        chk("R2 old value held", r, 0);
        rd(flag_reg(i), r);
        chk("R2 flag not yet", r & flag_mask(i), 0);
        @(negedge clk);
      end
      rd(reg_of(i), r);
      chk("R2 value landed", r, v);
      rd(flag_reg(i), r);
      chk("R2 flag set", r & flag_mask(i), flag_mask(i));
    end

    // R3 write-one-to-clear of flags
    rd(CWS, r); chk("R3 counter flags", r, 32'h3);
    rd(GWS, r); chk("R3 control flags", r, 32'h10007);
    wr(GWS, 32'h1);
    rd(GWS, r); chk("R3 clear one bit", r, 32'h10006);
    rd(CWS, r); chk("R3 other reg untouched", r, 32'h3);
    wr(CWS, 32'h2);
    rd(CWS, r); chk("R3 clear counter high flag", r, 32'h1);
    wr(CWS, 32'hFFFF_FFFF);
    wr(GWS, 32'hFFFF_FFFF);
    rd(CWS, r); chk("R3 all clear", r, 0);
    rd(GWS, r); chk("R3 all clear", r, 0);

    // R4 counter runs
    wr(CTRL, 32'h100); settle();
    rd(CNTL, a);
    repeat (7) @(negedge clk);
    rd(CNTL, b);
    chk("R4 advance by 7", b, a + 7);

    // R5 write while running is dropped, flag still sets
    wr(CNTL, 32'h0); settle();
    rd(CWS, r); chk("R5 flag on dropped write", r & 1, 1);
    rd(CNTL, c);
    chk("R5 counter kept running", c, b + 2 + D);
    wr(CTRL, 32'h0); settle();
    rd(CNTL, a);
    repeat (5) @(negedge clk);
    rd(CNTL, b);
    chk("R4 hold when stopped", b, a);
    wr(CWS, 32'h3);

    // R6 carry across halves
    wr(CNTL, 32'hFFFF_FFFC); wr(CNTH, 32'h1); settle();
    rd(CNTH, hi); rd(CNTL, lo);
    chk("R5 load while stopped", {hi, lo}, 64'h1_FFFF_FFFC);
    wr(CTRL, 32'h100); settle();
    rd(CNTH, hi); rd(CNTL, lo);
    prev = {hi, lo};
    chk("R6 start value", prev, 64'h1_FFFF_FFFC);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      rd(CNTH, hi); rd(CNTL, lo);
      cur = {hi, lo};
      chk("R6 step by one", cur, prev + 1);
      prev = cur;
    end
    chk("R6 after carry", prev, 64'h2_0000_0004);

    // R7 / R9 one-shot match
    wr(CTRL, 32'h0); settle();
    wr(CNTL, 32'd100); wr(CNTH, 32'd0); wr(CMPL, 32'd110); wr(CMPH, 32'd0);
    settle();
    wr(ISTAT, 32'h1);
    wr(CTRL, 32'h101);
    r = 0;
    for (int k = 0; k < 100; k++) begin
      rd(ISTAT, r);
      if (r[0]) break;
      @(negedge clk);
    end
    chk("R7 status set", r, 1);
    rd(CNTL, a);
    chk("R7 counter at compare+1", a, 111);
    chk("R7 irq gated off", irq, 0);
    rd(CMPL, r);
    chk("R9 compare unchanged", r, 110);
    wr(IEN, 32'h1);
    chk("R7 irq on enable", irq, 1);
    wr(ISTAT, 32'h1);
    rd(ISTAT, r);
    chk("R10 status cleared", r, 0);
    chk("R10 irq dropped", irq, 0);
    repeat (20) @(negedge clk);
    chk("R9 no repeat", irq, 0);

    // R8 periodic sweep
    foreach (incs[n]) begin
      wr(CTRL, 32'h0); settle();
      wr(CNTL, 32'd0); wr(CNTH, 32'd0); wr(CMPL, 32'd50); wr(CMPH, 32'd0);
      wr(INC, 32'(incs[n])); settle();
      wr(ISTAT, 32'h1);
      wr(CTRL, 32'h103);
      t0 = 0;
      for (int p = 0; p < 3; p++) begin
        for (int k = 0; k < 200; k++) begin
          if (irq) break;
          @(negedge clk);
        end
        chk("R8 irq seen", irq, 1);
        t = cyc;
        if (p > 0) chk("R8 period", t - t0, incs[n]);
        t0 = t;
        rd(CMPL, r);
        chk("R8 compare advanced", r, 32'(50 + (p + 1) * incs[n]));
        wr(ISTAT, 32'h1);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule